// File: doc/BRIEF.md
# Self-Draining Event Crossing FIFO

This block moves short tagged events, such as a waveform selector, from a source clock domain to an unrelated destination clock domain. A one-cycle strobe on the source side writes the data word present on the same cycle into a small asynchronous FIFO. The source side has no write enable and no ready signal. The write and read pointers cross between the domains as Gray codes through flop synchronizers.

The destination side has no ready input. Whenever the FIFO holds an entry, the block pops it and presents it with a valid pulse one destination clock wide. The data output keeps its value between pulses. The source is never stalled: a strobe that arrives while the FIFO is full is dropped, and an overrun flag pulses for one source cycle. Each domain has its own asynchronous active-low reset, synchronized to that domain's clock outside this block.

Top module: `evt_cdc_fifo`

## Requirements
- R1: Every source strobe that finds the FIFO not full is delivered at the destination exactly once, in the order the strobes were written, with its data word unchanged.
- R2: Each stored entry appears as a `dst_valid_o` pulse one destination cycle wide. `dst_valid_o` never rises while the FIFO holds no entry. Entries stored back to back may give valid on consecutive cycles.
- R3: `dst_data_o` changes only on a cycle where `dst_valid_o` is high, and it holds its last value between pulses.
- R4: A strobe that arrives while the FIFO is full is dropped. `overrun_o` is high for the one source cycle that follows that strobe. Entries already stored are delivered intact.
- R5: The write pointer and the read pointer each change by at most one bit per clock of their own domain (Gray code).
- R6: With both clocks running, an event written into an empty FIFO raises `dst_valid_o` after 2 to 4 destination clock edges, counted from half a source cycle after the write edge.
- R7: While the resets are active, `dst_valid_o`, `dst_data_o` and `overrun_o` are all 0 and the FIFO is empty.
- R8: Starting from an empty FIFO, DEPTH back-to-back source strobes are all accepted, with no overrun.
- R9: The occupancy seen from the source side never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| src_valid_i | input | 1 | Event strobe, one source cycle per event |
| src_data_i | input | DATA_W | Data word (tag) carried with the strobe |
| overrun_o | output | 1 | One-cycle pulse: the previous strobe was dropped because the FIFO was full |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid_o | output | 1 | One destination cycle per delivered event |
| dst_data_o | output | DATA_W | Data of the event just delivered, held between pulses |

## Verification
The overrun flag is registered, so it is due on the source cycle after the strobe. The driver samples it on the falling edge that follows the write edge. It then decides, before the next strobe, whether that event goes into the expected queue. A delivered event is due three destination edges after its write: two synchronizer stages, then the output register. The latency check counts destination edges from the write and accepts 2 to 4 to allow for phase. The scoreboard monitor samples on each destination falling edge and never assumes a fixed latency, so bursts at different clock ratios are compared in order.

// File: rtl/evt_cdc_pkg.sv
package evt_cdc_pkg;
  localparam int unsigned GRAY_MAX_W = 16;

  function automatic logic [GRAY_MAX_W-1:0] bin_to_gray(input logic [GRAY_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GRAY_MAX_W-1:0] gray_to_bin(input logic [GRAY_MAX_W-1:0] g);
    logic [GRAY_MAX_W-1:0] b;
    b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
    for (int i = GRAY_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/evt_cdc_sync.sv
module evt_cdc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/evt_cdc_mem.sv
module evt_cdc_mem #(
  parameter int unsigned DATA_W = 2,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset: a slot is read only after its pointer has crossed
  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/evt_cdc_wr.sv
module evt_cdc_wr
  import evt_cdc_pkg::*;
#(
  parameter int unsigned AW  = 2,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [PW-1:0] rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          overrun_o
);
  logic [PW-1:0]         wbin_q, wbin_nxt;
  logic [PW-1:0]         wgray_q;
  logic                  overrun_q;
  logic [GRAY_MAX_W-1:0] rbin_w, wgray_nxt;

  assign rbin_w = gray_to_bin(GRAY_MAX_W'(rgray_sync_i));
  assign full_o = (wbin_q[AW-1:0] == rbin_w[AW-1:0]) && (wbin_q[AW] != rbin_w[AW]);
  assign we_o   = valid_i && !full_o;

  assign wbin_nxt  = wbin_q + PW'(we_o);
  assign wgray_nxt = bin_to_gray(GRAY_MAX_W'(wbin_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      overrun_q <= 1'b0;
    end else begin
      wbin_q    <= wbin_nxt;
      wgray_q   <= wgray_nxt[PW-1:0];
      overrun_q <= valid_i && full_o;
    end
  end

  assign waddr_o   = wbin_q[AW-1:0];
  assign wgray_o   = wgray_q;
  assign overrun_o = overrun_q;
endmodule

// File: rtl/evt_cdc_rd.sv
module evt_cdc_rd
  import evt_cdc_pkg::*;
#(
  parameter int unsigned DATA_W = 2,
  parameter int unsigned AW     = 2,
  localparam int unsigned PW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PW-1:0]     wgray_sync_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic [PW-1:0]     rgray_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [PW-1:0]         rbin_q, rbin_nxt;
  logic [PW-1:0]         rgray_q;
  logic                  valid_q;
  logic [DATA_W-1:0]     data_q;
  logic                  pop;
  logic [GRAY_MAX_W-1:0] rgray_nxt;

  // self-draining: any stored entry is popped at once
  assign pop       = (rgray_q != wgray_sync_i);
  assign rbin_nxt  = rbin_q + PW'(pop);
  assign rgray_nxt = bin_to_gray(GRAY_MAX_W'(rbin_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rgray_nxt[PW-1:0];
      valid_q <= pop;
      if (pop) data_q <= rdata_i;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/evt_cdc_fifo.sv
module evt_cdc_fifo #(
  parameter int unsigned DATA_W      = 2,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned PW         = AW + 1
) (
  input  logic              src_clk_i,
  input  logic              src_rst_ni,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              overrun_o,
  input  logic              dst_clk_i,
  input  logic              dst_rst_ni,
  output logic              dst_valid_o,
  output logic [DATA_W-1:0] dst_data_o
);
  logic          we;
  logic          full;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_dst, rgray_src;
  logic [DATA_W-1:0] rdata;

  evt_cdc_wr #(.AW(AW)) u_wr (
    .clk_i        (src_clk_i),
    .rst_ni       (src_rst_ni),
    .valid_i      (src_valid_i),
    .rgray_sync_i (rgray_src),
    .we_o         (we),
    .waddr_o      (waddr),
    .wgray_o      (wgray),
    .full_o       (full),
    .overrun_o    (overrun_o)
  );

  evt_cdc_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk_i  (src_clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (src_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  evt_cdc_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2d (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_dst)
  );

  evt_cdc_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2s (
    .clk_i  (src_clk_i),
    .rst_ni (src_rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_src)
  );

  evt_cdc_rd #(.DATA_W(DATA_W), .AW(AW)) u_rd (
    .clk_i        (dst_clk_i),
    .rst_ni       (dst_rst_ni),
    .wgray_sync_i (wgray_dst),
    .rdata_i      (rdata),
    .raddr_o      (raddr),
    .rgray_o      (rgray),
    .valid_o      (dst_valid_o),
    .data_o       (dst_data_o)
  );
endmodule

// File: rtl/evt_cdc_fifo_chk.sv
module evt_cdc_fifo_chk
  import evt_cdc_pkg::*;
#(
  parameter int unsigned DATA_W = 2,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PW     = 3
) (
  input logic              src_clk_i,
  input logic              src_rst_ni,
  input logic              src_valid_i,
  input logic              overrun_o,
  input logic              full,
  input logic [PW-1:0]     wgray,
  input logic [PW-1:0]     rgray_src,
  input logic              dst_clk_i,
  input logic              dst_rst_ni,
  input logic              dst_valid_o,
  input logic [DATA_W-1:0] dst_data_o,
  input logic [PW-1:0]     rgray
);
  logic [GRAY_MAX_W-1:0] wbin_c, rbin_c;
  logic [PW-1:0]         level_c;
  assign wbin_c  = gray_to_bin(GRAY_MAX_W'(wgray));
  assign rbin_c  = gray_to_bin(GRAY_MAX_W'(rgray_src));
  assign level_c = wbin_c[PW-1:0] - rbin_c[PW-1:0];

  // R4
  overrun_cause_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    overrun_o |-> $past(src_valid_i));

  // R4
  full_hold_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    full |=> $stable(wgray));

  // R3
  data_hold_chk: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    !$stable(dst_data_o) |-> dst_valid_o);

  // R5
  wgray_step_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R5
  rgray_step_chk: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R9
  level_bound_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    level_c <= PW'(DEPTH));
endmodule

bind evt_cdc_fifo evt_cdc_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .src_clk_i   (src_clk_i),
  .src_rst_ni  (src_rst_ni),
  .src_valid_i (src_valid_i),
  .overrun_o   (overrun_o),
  .full        (full),
  .wgray       (wgray),
  .rgray_src   (rgray_src),
  .dst_clk_i   (dst_clk_i),
  .dst_rst_ni  (dst_rst_ni),
  .dst_valid_o (dst_valid_o),
  .dst_data_o  (dst_data_o),
  .rgray       (rgray)
);

// File: tb/sim_evt_cdc_fifo.sv
`timescale 1ns/1ps
module sim_evt_cdc_fifo;
  localparam int DATA_W = 2;
  localparam int DEPTH  = 4;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic src_valid = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic overrun;
  logic dst_valid;
  logic [DATA_W-1:0] dst_data;

  int dst_half = 10;
  int n_chk = 0, n_bad = 0, n_acc = 0, n_got = 0;
  logic [DATA_W-1:0] exp_q [$];
  logic [DATA_W-1:0] prev_data = '0;
  logic done = 1'b0;

  always #4 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  evt_cdc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .src_clk_i   (src_clk),
    .src_rst_ni  (src_rst_n),
    .src_valid_i (src_valid),
    .src_data_i  (src_data),
    .overrun_o   (overrun),
    .dst_clk_i   (dst_clk),
    .dst_rst_ni  (dst_rst_n),
    .dst_valid_o (dst_valid),
    .dst_data_o  (dst_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: call at a source falling edge; returns at the next one
  task automatic push(input logic [DATA_W-1:0] d, output bit ovf);
    src_valid = 1'b1;
    src_data  = d;
    @(posedge src_clk);
    @(negedge src_clk);
    src_valid = 1'b0;
    ovf = overrun;
    if (!ovf) begin
      exp_q.push_back(d);
      n_acc++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge src_clk);
    repeat (20) @(negedge src_clk);
  endtask

  // monitor / scoreboard (R1, R2, R3)
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_valid) begin
        n_got++;
        if (exp_q.size() == 0) check(1'b0, "R2 spurious valid", 1, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          check(dst_data == e, "R1 data/order", int'(dst_data), int'(e));
        end
      end else if (dst_data != prev_data) begin
        check(1'b0, "R3 data moved without valid", int'(dst_data), int'(prev_data));
      end
      prev_data = dst_data;
    end
  end

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ovf;
    int cnt, n_ovf;
    bit early_ovf;

    // R7 reset state
    repeat (5) @(negedge src_clk);
    check(!dst_valid, "R7 valid in reset", int'(dst_valid), 0);
    check(dst_data == '0, "R7 data in reset", int'(dst_data), 0);
    check(!overrun, "R7 overrun in reset", int'(overrun), 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (10) @(negedge src_clk);
    check(!dst_valid && !overrun, "R7 empty after reset", int'(dst_valid | overrun), 0);

    // R6 latency of an isolated event
    push(2'b01, ovf);
    check(!ovf, "R6 single push accepted", int'(ovf), 0);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge dst_clk);
      cnt++;
      if (dst_valid) break;
    end
    check(cnt >= 2 && cnt <= 4, "R6 latency", cnt, 3);
    @(negedge dst_clk);
    check(!dst_valid, "R2 pulse width one cycle", int'(dst_valid), 0);
    drain();

    // R8 depth back-to-back from empty
    @(negedge src_clk);
    n_ovf = 0;
    for (int i = 0; i < DEPTH; i++) begin
      push(DATA_W'(i + 1), ovf);
      if (ovf) n_ovf++;
    end
    check(n_ovf == 0, "R8 depth burst overruns", n_ovf, 0);
    drain();

    // R4 / R9 overflow with slow destination
    dst_half = 40;
    repeat (20) @(negedge src_clk);
    drain();
    @(negedge src_clk);
    n_ovf = 0;
    early_ovf = 1'b0;
    for (int i = 0; i < 10; i++) begin
      push(DATA_W'(i), ovf);
      if (ovf) n_ovf++;
      if (ovf && i < DEPTH) early_ovf = 1'b1;
    end
    check(n_ovf > 0, "R4 overrun seen on overfill", n_ovf, 1);
    check(!early_ovf, "R4 no overrun within depth", int'(early_ovf), 0);
    @(negedge src_clk);
    check(!overrun, "R4 overrun one cycle", int'(overrun), 0);
    drain();

    // R1 / R5 streaming with fast destination and irregular gaps
    dst_half = 3;
    repeat (10) @(negedge src_clk);
    for (int i = 0; i < 300; i++) begin
      push(DATA_W'($urandom), ovf);
      repeat ($urandom % 3) @(negedge src_clk);
    end
    drain();

    // R1 / R2 similar clocks, dense traffic
    dst_half = 5;
    repeat (10) @(negedge src_clk);
    for (int i = 0; i < 300; i++) begin
      push(DATA_W'($urandom), ovf);
      if ($urandom % 4 == 0) @(negedge src_clk);
    end
    drain();

    check(exp_q.size() == 0, "R1 all accepted delivered", exp_q.size(), 0);
    check(n_got == n_acc, "R1 delivered count", n_got, n_acc);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule